// File: doc/BRIEF.md
# Host Command Character Retimer

This block sits between a slow asynchronous host serial line and a single wire to a neighbouring chip. It receives each host command character at whatever baud rate the host uses, keeps the whole character, and then sends it again on the wire at one bit per system clock, synchronous to that clock. The neighbouring chip can therefore watch the complete command stream with a fixed-rate, clock-synchronous receiver. That receiver needs no baud setting and works from the first clock after reset.

The host side oversamples the line 16 times per bit. The oversampling tick comes from a divisor input, so one bit lasts `16 * baud_div` clocks. The receive state machine has seven states:
- `RX_IDLE`: waits for a falling edge.
- `RX_START`: confirms the start bit at its midpoint and goes back to `RX_IDLE` if the line is high again.
- `RX_DATA`: takes the data bits.
- `RX_STOP`: checks the stop bit. A high stop bit leads to `RX_DONE`, which lasts one cycle and reports the character. A low stop bit leads to `RX_FAULT`, which lasts one cycle and reports a framing error.
- `RX_BREAK`: entered from `RX_FAULT`; waits for the line to go high before returning to `RX_IDLE`.

A finished character goes into a one-entry holding register. The transmit state machine moves `TX_IDLE -> TX_SEND` when a character is held and nobody else wants the wire. It returns `TX_SEND -> TX_IDLE` after the tenth bit. It moves `TX_IDLE -> TX_LENT` when another source requests the wire, and `TX_LENT -> TX_IDLE` when that request drops. A local controller also sees every good character on a strobe.

Top module: `cmd_fwd_retimer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `fwd_out` is 1 and `alt_grant`, `fwd_busy`, `char_strobe`, `frame_err` and `overflow` are all 0.
- R2: A host frame is one low start bit, eight data bits sent LSB first, and one high stop bit. Each bit lasts 16*`baud_div` clocks, and a divisor of 0 acts as 1. A good frame raises `char_strobe` for one cycle, with the received value on `char_byte`.
- R3: Each good character appears on `fwd_out` as one low start bit, then the eight data bits LSB first, then one high stop bit. Every bit lasts exactly one clock, and the line rests at 1 between frames.
- R4: Forwarding begins only after the whole character is in. When the wire is free, `fwd_out` is still 1 in the cycle after the `char_strobe` cycle and carries the start bit in the cycle after that.
- R5: A low pulse on `host_rx` shorter than half a bit produces no character, no strobe and no forwarded frame.
- R6: A character whose stop bit is low raises `frame_err` for one cycle. It produces no strobe and no forwarded frame. The receiver then waits for the line to return high before it looks for the next start bit.
- R7: A good character that cannot be sent at once stays in the holding register. It is forwarded unchanged once the wire becomes free.
- R8: A good character that completes while the holding register is still full raises `overflow` for one cycle. The new character is dropped and the held one is kept.
- R9: `alt_req` is granted when no frame is in progress. `alt_grant` rises one cycle after the request and falls one cycle after the request is removed. While `alt_grant` is 1, `fwd_out` is 1.
- R10: `fwd_busy` is 1 while a frame is being sent or a character is held, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; forwarded bits change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_div | input | DIV_W | Clocks per oversampling tick (16 ticks per host bit) |
| host_rx | input | 1 | Asynchronous host serial line, idle high |
| alt_req | input | 1 | Another source asks for the forwarding wire |
| fwd_out | output | 1 | Forwarding wire, one bit per clock, idle high |
| alt_grant | output | 1 | Wire is lent to the other source |
| fwd_busy | output | 1 | Frame in progress or character held |
| char_strobe | output | 1 | One-cycle pulse: good character received |
| char_byte | output | 8 | Value of the last received character |
| frame_err | output | 1 | One-cycle pulse: stop bit was low |
| overflow | output | 1 | One-cycle pulse: character dropped, holding register full |

## Verification
The bench builds the block with `DIV_W = 8`. It runs at divisors of 4 and 3, so a host bit lasts 64 or 48 clocks and a whole character completes in well under a thousand cycles. That short bit time makes it practical to send many characters, including all-zero and all-one bytes. It also allows glitch pulses measured against the half-bit threshold and a deliberately low stop bit. Holding `alt_req` while two characters arrive is the only way the holding register can stay full, and this exercises both the held-character path and the overflow drop.

// File: rtl/cmdfwd_pkg.sv
package cmdfwd_pkg;

    localparam int unsigned OVS        = 16;
    localparam int unsigned OVS_W      = $clog2(OVS);
    localparam int unsigned HALF_TICKS = OVS / 2;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_DONE,
        RX_FAULT,
        RX_BREAK
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SEND,
        TX_LENT
    } tx_state_e;

endpackage

// File: rtl/cfw_tick_gen.sv
module cfw_tick_gen #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = (div == '0) ? DIV_W'(1) : div;
        tick  = (cnt_q >= limit - DIV_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/cfw_host_rx.sv
module cfw_host_rx
    import cmdfwd_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_in,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ferr
);

    localparam int unsigned BIDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    rx_state_e               state_q, state_d;
    logic [SYNC_STAGES-1:0]  sync_q;
    logic                    line;
    logic [OVS_W-1:0]        tcnt_q;
    logic [BIDX_W-1:0]       bidx_q;
    logic [DATA_W-1:0]       shreg_q;
    logic                    mid_start, bit_end;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
    end
    assign line = sync_q[SYNC_STAGES-1];

    assign mid_start = tick && (tcnt_q == OVS_W'(HALF_TICKS - 1));
    assign bit_end   = tick && (tcnt_q == OVS_W'(OVS - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (!line) state_d = RX_START;
            RX_START: if (mid_start) state_d = line ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_end && bidx_q == BIDX_W'(DATA_W - 1)) state_d = RX_STOP;
            RX_STOP:  if (bit_end) state_d = line ? RX_DONE : RX_FAULT;
            RX_DONE:  state_d = RX_IDLE;
            RX_FAULT: state_d = RX_BREAK;
            RX_BREAK: if (line) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    // counters and data shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt_q  <= '0;
            bidx_q  <= '0;
            shreg_q <= '0;
        end else begin
            unique case (state_q)
                RX_START: begin
                    if (mid_start)  tcnt_q <= '0;
                    else if (tick)  tcnt_q <= tcnt_q + OVS_W'(1);
                end
                RX_DATA: begin
                    if (bit_end) begin
                        tcnt_q  <= '0;
                        shreg_q <= {line, shreg_q[DATA_W-1:1]};
                        bidx_q  <= bidx_q + BIDX_W'(1);
                    end else if (tick) begin
                        tcnt_q <= tcnt_q + OVS_W'(1);
                    end
                end
                RX_STOP: begin
                    if (tick) tcnt_q <= tcnt_q + OVS_W'(1);
                end
                default: begin
                    tcnt_q <= '0;
                    bidx_q <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        rx_valid = (state_q == RX_DONE);
        rx_ferr  = (state_q == RX_FAULT);
        rx_data  = shreg_q;
    end

endmodule

// File: rtl/cfw_line_tx.sv
module cfw_line_tx
    import cmdfwd_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              alt_req,
    output logic              line_out,
    output logic              alt_grant,
    output logic              busy,
    output logic              ovf
);

    localparam int unsigned FRAME_W = DATA_W + 2;
    localparam int unsigned BCNT_W  = $clog2(FRAME_W);

    tx_state_e           state_q, state_d;
    logic                hold_full_q;
    logic [DATA_W-1:0]   hold_data_q;
    logic [FRAME_W-1:0]  shreg_q;
    logic [BCNT_W-1:0]   bcnt_q;
    logic                ovf_q;
    logic                take;

    assign take = (state_q == TX_IDLE) && hold_full_q && !alt_req;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: begin
                if (alt_req)          state_d = TX_LENT;
                else if (hold_full_q) state_d = TX_SEND;
            end
            TX_SEND: if (bcnt_q == BCNT_W'(FRAME_W - 1)) state_d = TX_IDLE;
            TX_LENT: if (!alt_req) state_d = TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    // holding register and shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full_q <= 1'b0;
            hold_data_q <= '0;
            shreg_q     <= '1;
            bcnt_q      <= '0;
            ovf_q       <= 1'b0;
        end else begin
            if (take) begin
                shreg_q <= {1'b1, hold_data_q, 1'b0};
                bcnt_q  <= '0;
            end else if (state_q == TX_SEND) begin
                shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
                bcnt_q  <= bcnt_q + BCNT_W'(1);
            end

            if (in_valid && (!hold_full_q || take)) begin
                hold_data_q <= in_data;
                hold_full_q <= 1'b1;
            end else if (take) begin
                hold_full_q <= 1'b0;
            end

            ovf_q <= in_valid && hold_full_q && !take;
        end
    end

    // outputs
    always_comb begin
        line_out  = (state_q == TX_SEND) ? shreg_q[0] : 1'b1;
        alt_grant = (state_q == TX_LENT);
        busy      = (state_q == TX_SEND) || hold_full_q;
        ovf       = ovf_q;
    end

endmodule

// File: rtl/cmd_fwd_retimer.sv
module cmd_fwd_retimer
    import cmdfwd_pkg::*;
#(
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              host_rx,
    input  logic              alt_req,
    output logic              fwd_out,
    output logic              alt_grant,
    output logic              fwd_busy,
    output logic              char_strobe,
    output logic [DATA_W-1:0] char_byte,
    output logic              frame_err,
    output logic              overflow
);

    logic tick;

    cfw_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (baud_div),
        .tick  (tick)
    );

    cfw_host_rx #(.DATA_W(DATA_W), .SYNC_STAGES(2)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .rx_in    (host_rx),
        .rx_valid (char_strobe),
        .rx_data  (char_byte),
        .rx_ferr  (frame_err)
    );

    cfw_line_tx #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (char_strobe),
        .in_data   (char_byte),
        .alt_req   (alt_req),
        .line_out  (fwd_out),
        .alt_grant (alt_grant),
        .busy      (fwd_busy),
        .ovf       (overflow)
    );

endmodule

// File: rtl/cfw_checker.sv
module cfw_checker (
    input logic clk,
    input logic rst_n,
    input logic alt_req,
    input logic fwd_out,
    input logic alt_grant,
    input logic fwd_busy,
    input logic char_strobe,
    input logic frame_err,
    input logic overflow
);

    a_r9_line_high_when_lent: assert property (@(posedge clk) disable iff (!rst_n)
        alt_grant |-> fwd_out);

    a_r9_grant_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alt_grant) |-> $past(alt_req));

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_req |=> !alt_grant);

    a_r6_err_not_char: assert property (@(posedge clk) disable iff (!rst_n)
        !(char_strobe && frame_err));

    a_r8_overflow_busy: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> fwd_busy);

    a_r10_busy_after_char: assert property (@(posedge clk) disable iff (!rst_n)
        char_strobe |=> fwd_busy);

endmodule

bind cmd_fwd_retimer cfw_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alt_req     (alt_req),
    .fwd_out     (fwd_out),
    .alt_grant   (alt_grant),
    .fwd_busy    (fwd_busy),
    .char_strobe (char_strobe),
    .frame_err   (frame_err),
    .overflow    (overflow)
);

// File: tb/tb_cmd_fwd_retimer.sv
module tb_cmd_fwd_retimer;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] baud_div = 8'd4;
    logic             host_rx = 1'b1;
    logic             alt_req = 1'b0;
    logic             fwd_out, alt_grant, fwd_busy, char_strobe, frame_err, overflow;
    logic [7:0]       char_byte;

    int errs = 0, checks = 0;
    int frames = 0, strobes = 0, ferrs = 0, ovfs = 0;
    bit r4_armed = 1'b0;
    bit done = 1'b0;
    logic [7:0] q_fwd[$];
    logic [7:0] q_loc[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_fwd_retimer #(.DIV_W(DIV_W), .DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .host_rx(host_rx),
        .alt_req(alt_req), .fwd_out(fwd_out), .alt_grant(alt_grant),
        .fwd_busy(fwd_busy), .char_strobe(char_strobe), .char_byte(char_byte),
        .frame_err(frame_err), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: sends one host frame, pushing expectations first
    task automatic send_host(input logic [7:0] b, input bit stop_ok, input bit fwd_exp);
        int bt;
        bt = 16 * int'(baud_div);
        if (stop_ok) begin
            q_loc.push_back(b);
            if (fwd_exp) q_fwd.push_back(b);
        end
        @(posedge clk); host_rx <= 1'b0;
        repeat (bt) @(posedge clk);
        for (int i = 0; i < 8; i++) begin
            host_rx <= b[i];
            repeat (bt) @(posedge clk);
        end
        host_rx <= stop_ok;
        repeat (bt) @(posedge clk);
        host_rx <= 1'b1;
        repeat (bt) @(posedge clk);
    endtask

    // monitor: decodes forwarded frames at one bit per clock (R3)
    initial begin
        logic [7:0] got;
        forever begin
            @(negedge clk);
            if (rst_n && fwd_out === 1'b0) begin
                for (int i = 0; i < 8; i++) begin
                    @(negedge clk);
                    got[i] = fwd_out;
                end
                @(negedge clk);
                frames++;
                check(fwd_out === 1'b1, "R3 stop bit", int'(fwd_out), 1);
                if (q_fwd.size() == 0) begin
                    check(1'b0, "R3 unexpected frame", int'(got), 0);
                end else begin
                    logic [7:0] e;
                    e = q_fwd.pop_front();
                    check(got === e, "R3 forwarded byte", int'(got), int'(e));
                end
            end
        end
    end

    // monitor: local strobe, pulse counters, R4 start timing
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (frame_err) ferrs++;
                if (overflow)  ovfs++;
                if (char_strobe) begin
                    strobes++;
                    if (q_loc.size() == 0) begin
                        check(1'b0, "R2 unexpected strobe", int'(char_byte), 0);
                    end else begin
                        logic [7:0] e;
                        e = q_loc.pop_front();
                        check(char_byte === e, "R2 received byte", int'(char_byte), int'(e));
                    end
                    if (r4_armed) begin
                        @(negedge clk);
                        check(fwd_out === 1'b1, "R4 line idle after strobe", int'(fwd_out), 1);
                        @(negedge clk);
                        check(fwd_out === 1'b0, "R4 start two cycles after strobe", int'(fwd_out), 0);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int f0, s0, e0, o0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(fwd_out === 1'b1 && alt_grant === 1'b0 && fwd_busy === 1'b0, "R1 reset line",
              int'({fwd_out, alt_grant, fwd_busy}), 3'b100);
        check(char_strobe === 1'b0 && frame_err === 1'b0 && overflow === 1'b0, "R1 reset pulses",
              int'({char_strobe, frame_err, overflow}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(fwd_out === 1'b1 && fwd_busy === 1'b0, "R1 after release",
              int'({fwd_out, fwd_busy}), 2'b10);

        // R2 R3 R4 patterns at divisor 4
        r4_armed = 1'b1;
        send_host(8'hA5, 1'b1, 1'b1);
        send_host(8'h00, 1'b1, 1'b1);
        send_host(8'hFF, 1'b1, 1'b1);
        send_host(8'h3C, 1'b1, 1'b1);
        send_host(8'h96, 1'b1, 1'b1);
        // divisor 3
        baud_div = 8'd3;
        send_host(8'h5A, 1'b1, 1'b1);
        send_host(8'h81, 1'b1, 1'b1);
        repeat (40) @(posedge clk);
        @(negedge clk);
        check(q_fwd.size() == 0, "R3 all forwarded", q_fwd.size(), 0);
        check(q_loc.size() == 0, "R2 all strobed", q_loc.size(), 0);
        check(frames == 7, "R3 frame count", frames, 7);
        check(fwd_busy === 1'b0, "R10 idle when drained", int'(fwd_busy), 0);

        // R5 short glitch: 12 clocks < 24 (half bit at divisor 3)
        s0 = strobes; f0 = frames;
        @(negedge clk); host_rx = 1'b0;
        repeat (12) @(negedge clk);
        host_rx = 1'b1;
        repeat (16 * 3 * 12) @(negedge clk);
        check(strobes == s0, "R5 glitch no strobe", strobes, s0);
        check(frames == f0, "R5 glitch no frame", frames, f0);

        // R6 framing error then recovery
        e0 = ferrs;
        send_host(8'h42, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        check(ferrs == e0 + 1, "R6 frame_err pulse", ferrs, e0 + 1);
        check(strobes == s0, "R6 no strobe", strobes, s0);
        check(frames == f0, "R6 no frame", frames, f0);
        send_host(8'h99, 1'b1, 1'b1);
        repeat (20) @(negedge clk);
        check(frames == f0 + 1, "R6 recovery frame", frames, f0 + 1);

        // R9 grant, R7 hold, R8 overflow
        r4_armed = 1'b0;
        @(negedge clk); alt_req = 1'b1;
        @(negedge clk);
        check(alt_grant === 1'b1, "R9 grant next cycle", int'(alt_grant), 1);
        check(fwd_out === 1'b1, "R9 line high when lent", int'(fwd_out), 1);
        f0 = frames; o0 = ovfs;
        send_host(8'h11, 1'b1, 1'b1);
        @(negedge clk);
        check(fwd_busy === 1'b1, "R10 busy while held", int'(fwd_busy), 1);
        check(frames == f0, "R7 held not sent during grant", frames, f0);
        check(fwd_out === 1'b1, "R9 line stays high", int'(fwd_out), 1);
        send_host(8'h22, 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        check(ovfs == o0 + 1, "R8 overflow pulse", ovfs, o0 + 1);
        alt_req = 1'b0;
        @(negedge clk);
        check(alt_grant === 1'b0, "R9 release next cycle", int'(alt_grant), 0);
        repeat (30) @(negedge clk);
        check(frames == f0 + 1, "R7 R8 only held char sent", frames, f0 + 1);
        check(q_fwd.size() == 0, "R7 held char forwarded", q_fwd.size(), 0);
        check(fwd_busy === 1'b0, "R10 idle at end", int'(fwd_busy), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule